// File: doc/BRIEF.md
# Packet Mask/Match Filter

This block sits beside an outbound packet path and watches each header as it leaves. Software loads a pattern (the MATCH register) and a bit-select (the MASK register), then turns filtering on. From then on, every valid header that agrees with the programmed pattern produces a one-cycle `match_pulse`, which an external event counter can tally.

The fields compared are the opcode, message class, response code, home node ID and physical address. The address and the node ID are compared bit by bit under an explicit mask. The opcode, class and response fields have no mask bits. Instead, each of them is skipped whenever its programmed value is zero.

Configuration goes through a simple register port with a select, write strobe, write data and combinational read data. A configuration register holds the single enable bit. While that bit is set, the MATCH and MASK registers are write-locked. A write to either of them is dropped and answered with a one-cycle error pulse.

Top module: `pkt_filter`

## Requirements
- R1: After reset, the enable bit and both MATCH and MASK read as zero, and `match_pulse` and `reg_err` are low.
- R2: An address or node ID bit is compared only where its MASK bit is 1. A MASK bit of 0 makes that bit don't-care.
- R3: Opcode, message class and response must each equal the programmed value, except that a field programmed as zero always qualifies.
- R4: Select 0 is the configuration register. Bit 63 is the enable, and bits 62:0 always read 0 whatever was written.
- R5: `match_pulse` is high in the cycle after a clock edge at which `pkt_valid` was high, the enable register was 1 and every field qualified. In all other cycles it is low.
- R6: MATCH is select 1 and holds address in bits 39:0, node ID in 45:40, response in 47:46, class in 50:48 and opcode in 54:51. MASK is select 2 and holds the address mask in bits 39:0 and the node mask in 45:40. All other bits read 0, and select 3 reads 0.
- R7: A write to select 1 or 2 while the enable is 1 leaves the register unchanged and raises `reg_err` for exactly the next cycle.
- R8: `reg_err` stays low for all other writes. Writes to MATCH or MASK while the enable is 0 take effect at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Header on the packet inputs is valid this cycle |
| pkt_opcode | input | 4 | Packet opcode |
| pkt_class | input | 3 | Packet message class |
| pkt_resp | input | 2 | Packet response code |
| pkt_node | input | 6 | Packet home node ID |
| pkt_addr | input | 40 | Packet physical address |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 config, 1 MATCH, 2 MASK |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data for the selected register |
| reg_err | output | 1 | One-cycle access-fault pulse for a locked write |
| match_pulse | output | 1 | One-cycle pulse for a qualifying packet |

## Verification
The assertions take for granted that reset is held low for at least one clock edge before any write or packet arrives. They also assume that `reg_sel` and `reg_wr` are free of unknowns whenever reset is high. The `$past` terms after reset depend on that. The bench drives every input from defined values on the falling edge, keeps reset asserted for several cycles, and only then starts its register writes and its packets.

// File: rtl/pkt_filter.sv
module pkt_filter #(
  parameter int OPC_W = 4,
  parameter int CLS_W = 3,
  parameter int RSP_W = 2,
  parameter int NID_W = 6,
  parameter int ADR_W = 40,
  parameter int REG_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [OPC_W-1:0] pkt_opcode,
  input  logic [CLS_W-1:0] pkt_class,
  input  logic [RSP_W-1:0] pkt_resp,
  input  logic [NID_W-1:0] pkt_node,
  input  logic [ADR_W-1:0] pkt_addr,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             reg_err,
  output logic             match_pulse
);
  localparam int NID_LSB = ADR_W;
  localparam int RSP_LSB = NID_LSB + NID_W;
  localparam int CLS_LSB = RSP_LSB + RSP_W;
  localparam int OPC_LSB = CLS_LSB + CLS_W;
  localparam int MATCH_W = OPC_LSB + OPC_W;
  localparam int MASK_W  = ADR_W + NID_W;

  logic               en_q;
  logic [MATCH_W-1:0] mt_q;
  logic [MASK_W-1:0]  mk_q;
  logic               err_q;
  logic               hit_q;

  wire sel_pair  = (reg_sel == 2'd1) || (reg_sel == 2'd2);
  wire locked_wr = reg_wr && en_q && sel_pair;
  wire open_wr   = reg_wr && !en_q;
  wire unused_wdata = ^reg_wdata[REG_W-2:MATCH_W];

  wire [ADR_W-1:0] m_addr = mt_q[ADR_W-1:0];
  wire [NID_W-1:0] m_node = mt_q[NID_LSB +: NID_W];
  wire [RSP_W-1:0] m_resp = mt_q[RSP_LSB +: RSP_W];
  wire [CLS_W-1:0] m_cls  = mt_q[CLS_LSB +: CLS_W];
  wire [OPC_W-1:0] m_opc  = mt_q[OPC_LSB +: OPC_W];
  wire [ADR_W-1:0] k_addr = mk_q[ADR_W-1:0];
  wire [NID_W-1:0] k_node = mk_q[NID_LSB +: NID_W];

  wire opc_ok  = (m_opc == '0)  || (pkt_opcode == m_opc);
  wire cls_ok  = (m_cls == '0)  || (pkt_class == m_cls);
  wire rsp_ok  = (m_resp == '0) || (pkt_resp == m_resp);
  wire node_ok = ((pkt_node ^ m_node) & k_node) == '0;
  wire addr_ok = ((pkt_addr ^ m_addr) & k_addr) == '0;
  wire hit     = opc_ok && cls_ok && rsp_ok && node_ok && addr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      mt_q  <= '0;
      mk_q  <= '0;
      err_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      err_q <= locked_wr;
      hit_q <= pkt_valid && en_q && hit;
      if (reg_wr && reg_sel == 2'd0) en_q <= reg_wdata[REG_W-1];
      if (open_wr && reg_sel == 2'd1) mt_q <= reg_wdata[MATCH_W-1:0];
      if (open_wr && reg_sel == 2'd2) mk_q <= reg_wdata[MASK_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      2'd0:    reg_rdata[REG_W-1] = en_q;
      2'd1:    reg_rdata[MATCH_W-1:0] = mt_q;
      2'd2:    reg_rdata[MASK_W-1:0] = mk_q;
      default: reg_rdata = '0;
    endcase
  end

  assign reg_err     = err_q;
  assign match_pulse = hit_q;
endmodule

// File: rtl/pkt_filter_chk.sv
module pkt_filter_chk #(
  parameter int MATCH_W = 55,
  parameter int MASK_W  = 46,
  parameter int REG_W   = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [1:0]         reg_sel,
  input logic [REG_W-1:0]   reg_wdata,
  input logic [REG_W-1:0]   reg_rdata,
  input logic               reg_err,
  input logic               pkt_valid,
  input logic               match_pulse,
  input logic               en_q,
  input logic [MATCH_W-1:0] mt_q,
  input logic [MASK_W-1:0]  mk_q
);
  a_r5_pulse_needs_valid_enable: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(pkt_valid) && $past(en_q));

  a_r7_locked_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && en_q && (reg_sel == 2'd1 || reg_sel == 2'd2)) |=> reg_err && $stable(mt_q) && $stable(mk_q));

  a_r8_err_only_locked: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |-> $past(reg_wr) && $past(en_q));

  a_r8_open_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !en_q && reg_sel == 2'd1) |=> !reg_err && mt_q == $past(reg_wdata[MATCH_W-1:0]));

  a_r4_cfg_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd0) |-> reg_rdata[REG_W-2:0] == '0);

  a_r6_sel3_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd3) |-> reg_rdata == '0);
endmodule

bind pkt_filter pkt_filter_chk #(.MATCH_W(MATCH_W), .MASK_W(MASK_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/pkt_filter_bench.sv
module pkt_filter_bench;
  logic clk = 0, rst_n = 0;
  logic pkt_valid = 0;
  logic [3:0] pkt_opcode = 0;
  logic [2:0] pkt_class = 0;
  logic [1:0] pkt_resp = 0;
  logic [5:0] pkt_node = 0;
  logic [39:0] pkt_addr = 0;
  logic reg_wr = 0;
  logic [1:0] reg_sel = 0;
  logic [63:0] reg_wdata = 0;
  logic [63:0] reg_rdata;
  logic reg_err, match_pulse;

  int compared = 0, mismatched = 0;

  logic m_en = 0;
  logic [54:0] m_match = 0;
  logic [45:0] m_mask = 0;

  pkt_filter u_pkt_filter (.*);

  always #10 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic exp_hit(logic [3:0] op, logic [2:0] cl, logic [1:0] rs,
                                   logic [5:0] nd, logic [39:0] ad);
    logic [3:0] mo = m_match[54:51];
    logic [2:0] mc = m_match[50:48];
    logic [1:0] mr = m_match[47:46];
    logic ok;
    ok = (mo == 0 || mo == op) && (mc == 0 || mc == cl) && (mr == 0 || mr == rs);
    ok = ok && (((nd ^ m_match[45:40]) & m_mask[45:40]) == 0);
    ok = ok && (((ad ^ m_match[39:0]) & m_mask[39:0]) == 0);
    return ok;
  endfunction

  task automatic wr(logic [1:0] sel, logic [63:0] d);
    logic locked = m_en && (sel == 1 || sel == 2);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_wr = 0;
    chk(sel == 0 ? "R8" : (locked ? "R7" : "R8"), {63'd0, reg_err}, {63'd0, locked});
    if (sel == 0) m_en = d[63];
    else if (sel == 1 && !m_en) m_match = d[54:0];
    else if (sel == 2 && !m_en) m_mask = d[45:0];
  endtask

  task automatic rd(string req, logic [1:0] sel);
    logic [63:0] e;
    reg_sel = sel; #1;
    case (sel)
      2'd0: e = {m_en, 63'd0};
      2'd1: e = {9'd0, m_match};
      2'd2: e = {18'd0, m_mask};
      default: e = 0;
    endcase
    chk(req, reg_rdata, e);
  endtask

  task automatic pkt(string req, logic v, logic [3:0] op, logic [2:0] cl, logic [1:0] rs,
                     logic [5:0] nd, logic [39:0] ad);
    logic e = v && m_en && exp_hit(op, cl, rs, nd, ad);
    pkt_valid = v; pkt_opcode = op; pkt_class = cl; pkt_resp = rs; pkt_node = nd; pkt_addr = ad;
    tick();
    pkt_valid = 0;
    chk(req, {63'd0, match_pulse}, {63'd0, e});
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (4) @(negedge clk);
    rst_n = 1;
    chk("R1", {62'd0, reg_err, match_pulse}, 64'd0);
    rd("R1", 0); rd("R1", 1); rd("R1", 2);

    wr(0, 64'h7fff_ffff_ffff_ffff); rd("R4", 0);
    wr(1, '1); rd("R6", 1);
    wr(2, '1); rd("R6", 2); rd("R6", 3);

    // enable off: a matching packet must not pulse (R5)
    pkt("R5", 1, 4'hf, 3'h7, 2'h3, 6'h3f, 40'hff_ffff_ffff);
    wr(0, 64'h8000_0000_0000_0000); rd("R4", 0);
    pkt("R5", 1, 4'hf, 3'h7, 2'h3, 6'h3f, 40'hff_ffff_ffff);
    pkt("R5", 0, 4'hf, 3'h7, 2'h3, 6'h3f, 40'hff_ffff_ffff);
    pkt("R2", 1, 4'hf, 3'h7, 2'h3, 6'h3f, 40'hff_ffff_fffe);
    pkt("R3", 1, 4'he, 3'h7, 2'h3, 6'h3f, 40'hff_ffff_ffff);

    // locked writes (R7)
    wr(1, 64'h0); rd("R7", 1);
    wr(2, 64'h0); rd("R7", 2);

    // zero-valued fields are don't-care (R3), zero mask is don't-care (R2)
    wr(0, 0);
    wr(1, 64'h0); wr(2, 64'h0);
    wr(0, 64'h8000_0000_0000_0000);
    pkt("R3", 1, 4'h3, 3'h5, 2'h1, 6'h2a, 40'h12_3456_789a);
    wr(0, 0);
    wr(1, {9'd0, 4'h0, 3'h2, 2'h0, 6'h00, 40'h0});
    wr(0, 64'h8000_0000_0000_0000);
    pkt("R3", 1, 4'h9, 3'h2, 2'h3, 6'h11, 40'h0);
    pkt("R3", 1, 4'h9, 3'h3, 2'h3, 6'h11, 40'h0);

    for (int g = 0; g < 60; g++) begin
      logic [63:0] mv, kv;
      wr(0, 0);
      mv = {$urandom, $urandom};
      if ($urandom_range(0, 2) == 0) mv[54:51] = 0;
      if ($urandom_range(0, 2) == 0) mv[50:48] = 0;
      if ($urandom_range(0, 2) == 0) mv[47:46] = 0;
      kv = {$urandom, $urandom};
      wr(1, mv); rd("R6", 1);
      wr(2, kv); rd("R6", 2);
      wr(0, {$urandom_range(0, 5) != 0, 63'($urandom)});
      for (int p = 0; p < 80; p++) begin
        logic [3:0] op = 4'($urandom); logic [2:0] cl = 3'($urandom);
        logic [1:0] rs = 2'($urandom); logic [5:0] nd = 6'($urandom);
        logic [39:0] ad = {8'($urandom), 32'($urandom)};
        if ($urandom_range(0, 1) == 1) begin
          if (m_match[54:51] != 0) op = m_match[54:51];
          if (m_match[50:48] != 0) cl = m_match[50:48];
          if (m_match[47:46] != 0) rs = m_match[47:46];
          nd = (m_match[45:40] & m_mask[45:40]) | (nd & ~m_mask[45:40]);
          ad = (m_match[39:0] & m_mask[39:0]) | (ad & ~m_mask[39:0]);
          if ($urandom_range(0, 3) == 0) ad[$urandom_range(0, 39)] ^= 1'b1;
        end
        pkt("R5", $urandom_range(0, 7) != 0, op, cl, rs, nd, ad);
        if ($urandom_range(0, 19) == 0) begin
          wr(2'($urandom_range(1, 2)), {$urandom, $urandom});
          rd("R7", 1); rd("R7", 2);
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule